// File: doc/BRIEF.md
# Two-Wire Debug Frame Master

This block is the master side of a two-wire debug link: one clock line that it always drives, and one data line that it drives or releases through an output enable. A host gives a command code, a write byte and a one-cycle start strobe. The block then runs one complete frame on the link and pulses `done`. A frame is an address-register write, an address-register read, a data-register write or a data-register read, each carrying one byte. A fifth command issues a long low pulse on the clock that the target takes as a reset.

Every clock strobe is a low phase followed by a high phase. Both lengths are counted in system clock cycles derived from `CLK_MHZ`. A normal low phase stays well below the five-microsecond limit at which the target would see a reset. Data-register frames carry a wait phase in which the target signals readiness by driving the data line high. If the target is not ready after a bounded number of wait strobes, the frame is abandoned and the timeout flag is raised. The data input passes through a synchronizer before it is sampled, and it is sampled in the last cycle of each strobe.

Top module: `tw_dbg_master`

## Requirements
- R1: After reset, `ck_o` is 1, `ck_oe`, `td_oe`, `done`, `busy` and `tmo_err` are 0, and `rd_byte` is 0. Whenever `busy` is 0, `ck_o` is 1 and `td_oe` is 0.
- R2: Every frame strobe holds `ck_o` low for exactly `CLK_MHZ*LOW_US` cycles, which must be below `5*CLK_MHZ`. Between two strobes of a frame, `ck_o` stays high for at least `CLK_MHZ*HIGH_US` cycles.
- R3: Command 4 produces one strobe with the data line released. Its low phase lasts exactly `CLK_MHZ*RESET_US` cycles, after which the clock returns high and `done` pulses.
- R4: Every frame starts with one strobe that has `td_oe`=0. A frame that completes normally ends with one more strobe that has `td_oe`=0.
- R5: The second and third strobes drive a 2-bit instruction code, bit 0 first, with `td_oe`=1. The codes are 11 for command 0 (address write), 10 for command 1 (address read), 01 for command 2 (data write) and 00 for command 3 (data read).
- R6: Data-register frames (commands 2 and 3) drive two further 0 bits after the instruction code. Address-register frames have no such field.
- R7: Write frames (commands 0 and 2) drive `wr_byte` with `td_oe`=1, bit 0 first, one bit per strobe.
- R8: Read frames (commands 1 and 3) release the data line for eight strobes and shift the sampled bit in from the top, so the first bit becomes bit 0. `rd_byte` takes the new byte when a read frame completes. Any other frame, and any aborted frame, leaves `rd_byte` unchanged.
- R9: In data-register frames the master releases the line and strobes until it samples 1 at the end of a strobe. The wait comes after the byte for command 2 and before the byte for command 3.
- R10: If `WAIT_TRIES` wait strobes all sample 0, the frame ends without its closing strobe, `tmo_err` is set, and `done` still pulses. `tmo_err` stays 1 until the next accepted start.
- R11: `start` is accepted only when the block is idle, `link_en` is 1 and `cmd` is 0 to 4. Any other start does nothing. `done` is a one-cycle pulse issued once at the end of every accepted frame.
- R12: `ck_oe` follows `link_en` one cycle later, and `ck_o` is already 1 when `ck_oe` rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| link_en | input | 1 | Enables driving the link |
| start | input | 1 | One-cycle request to run a frame |
| cmd | input | 3 | 0 addr write, 1 addr read, 2 data write, 3 data read, 4 target reset |
| wr_byte | input | 8 | Byte sent by write frames |
| rd_byte | output | 8 | Byte received by the last completed read frame |
| done | output | 1 | One-cycle pulse at the end of each frame |
| busy | output | 1 | A frame is in progress |
| tmo_err | output | 1 | Last frame ended on a wait timeout |
| ck_o | output | 1 | Link clock level |
| ck_oe | output | 1 | Link clock output enable |
| td_o | output | 1 | Link data level when driven |
| td_oe | output | 1 | Link data output enable |
| td_i | input | 1 | Link data line as seen at the pin |

## Verification
A small configuration (4 MHz, so strobe phases of four cycles and a 100-cycle reset pulse) runs every frame type over a spread of bytes that includes all zeros and all ones. The bench replays each frame's drive pattern strobe by strobe, so a wrong instruction code, a missing length field, reversed bit order or a misplaced wait phase shows up at a distinct strobe position. Wait lengths are swept from one strobe up to exactly the limit and one past it, which separates an off-by-one in the timeout counter from a correct abort. Intruding starts, disabled-link starts and undefined command codes confirm that nothing runs twice and that nothing runs when it should not.

// File: rtl/tw_dbg_pkg.sv
package tw_dbg_pkg;

  typedef enum logic [2:0] {
    OP_AR_WR = 3'd0,
    OP_AR_RD = 3'd1,
    OP_DR_WR = 3'd2,
    OP_DR_RD = 3'd3,
    OP_RESET = 3'd4
  } tw_op_e;

  typedef enum logic [3:0] {
    PH_IDLE,
    PH_START,
    PH_INS,
    PH_LEN,
    PH_WBYTE,
    PH_WAIT,
    PH_RBYTE,
    PH_STOP,
    PH_RST,
    PH_END
  } tw_phase_e;

  typedef enum logic [1:0] {
    SG_IDLE,
    SG_LOW,
    SG_HIGH
  } tw_sg_e;

  // Instruction code per frame type, transmitted bit 0 first
  function automatic logic [1:0] ins_code(input tw_op_e op);
    case (op)
      OP_AR_WR: ins_code = 2'b11;
      OP_AR_RD: ins_code = 2'b10;
      OP_DR_WR: ins_code = 2'b01;
      default:  ins_code = 2'b00;
    endcase
  endfunction

endpackage

// File: rtl/tw_strobe_gen.sv
module tw_strobe_gen
  import tw_dbg_pkg::*;
#(
  parameter int LOW_CYC  = 50,
  parameter int HIGH_CYC = 50,
  parameter int RST_CYC  = 1250
) (
  input  logic clk,
  input  logic rst,
  input  logic go,
  input  logic long_low,
  output logic ck_o,
  output logic fin
);

  localparam int MAX_LH = (LOW_CYC > HIGH_CYC) ? LOW_CYC : HIGH_CYC;
  localparam int MAXC   = (RST_CYC > MAX_LH) ? RST_CYC : MAX_LH;
  localparam int CW     = $clog2(MAXC + 1);

  tw_sg_e        st;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      st   <= SG_IDLE;
      cnt  <= '0;
      ck_o <= 1'b1;
      fin  <= 1'b0;
    end else begin
      fin <= 1'b0;
      case (st)
        SG_IDLE: begin
          if (go) begin
            st   <= SG_LOW;
            ck_o <= 1'b0;
            cnt  <= long_low ? CW'(RST_CYC - 1) : CW'(LOW_CYC - 1);
          end
        end
        SG_LOW: begin
          if (cnt == '0) begin
            st   <= SG_HIGH;
            ck_o <= 1'b1;
            cnt  <= CW'(HIGH_CYC - 1);
          end else begin
            cnt <= cnt - CW'(1);
          end
        end
        SG_HIGH: begin
          if (cnt == '0) begin
            st  <= SG_IDLE;
            fin <= 1'b1;
          end else begin
            cnt <= cnt - CW'(1);
          end
        end
        default: st <= SG_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/tw_frame_seq.sv
module tw_frame_seq
  import tw_dbg_pkg::*;
#(
  parameter int WAIT_TRIES = 20
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       start,
  input  logic       link_en,
  input  logic [2:0] cmd,
  input  logic [7:0] wr_byte,
  input  logic       td_s,
  input  logic       fin,
  output logic       go,
  output logic       long_low,
  output logic       td_o,
  output logic       td_oe,
  output logic       busy,
  output logic       done,
  output logic       tmo_err,
  output logic [7:0] rd_byte,
  output tw_op_e     op_q
);

  localparam int WW = $clog2(WAIT_TRIES + 1);
  localparam logic [WW-1:0] WAIT_LAST = WW'(WAIT_TRIES - 1);

  tw_phase_e     ph;
  logic          armed;
  logic [2:0]    bit_cnt;
  logic [WW-1:0] wait_cnt;
  logic [7:0]    wb_q;
  logic [7:0]    sh;
  logic          is_dr;
  logic          is_rd;
  logic [1:0]    ins;
  logic          cmd_ok;

  assign is_dr  = (op_q == OP_DR_WR) || (op_q == OP_DR_RD);
  assign is_rd  = (op_q == OP_AR_RD) || (op_q == OP_DR_RD);
  assign ins    = ins_code(op_q);
  assign cmd_ok = (cmd <= 3'd4);

  always_ff @(posedge clk) begin
    if (rst) begin
      ph       <= PH_IDLE;
      armed    <= 1'b0;
      bit_cnt  <= '0;
      wait_cnt <= '0;
      wb_q     <= '0;
      sh       <= '0;
      op_q     <= OP_AR_WR;
      go       <= 1'b0;
      long_low <= 1'b0;
      td_o     <= 1'b0;
      td_oe    <= 1'b0;
      busy     <= 1'b0;
      done     <= 1'b0;
      tmo_err  <= 1'b0;
      rd_byte  <= '0;
    end else begin
      go   <= 1'b0;
      done <= 1'b0;
      case (ph)
        PH_IDLE: begin
          if (start && link_en && cmd_ok) begin
            op_q     <= tw_op_e'(cmd);
            wb_q     <= wr_byte;
            tmo_err  <= 1'b0;
            busy     <= 1'b1;
            armed    <= 1'b0;
            bit_cnt  <= '0;
            wait_cnt <= '0;
            ph       <= (cmd == 3'd4) ? PH_RST : PH_START;
          end
        end
        PH_END: begin
          done  <= 1'b1;
          busy  <= 1'b0;
          td_oe <= 1'b0;
          ph    <= PH_IDLE;
          if (!tmo_err && is_rd) rd_byte <= sh;
        end
        default: begin
          if (!armed) begin
            // launch the strobe for the current bit, data set one cycle ahead
            go       <= 1'b1;
            armed    <= 1'b1;
            long_low <= (ph == PH_RST);
            case (ph)
              PH_INS: begin
                td_oe <= 1'b1;
                td_o  <= ins[bit_cnt[0]];
              end
              PH_LEN: begin
                td_oe <= 1'b1;
                td_o  <= 1'b0;
              end
              PH_WBYTE: begin
                td_oe <= 1'b1;
                td_o  <= wb_q[bit_cnt];
              end
              default: begin
                td_oe <= 1'b0;
                td_o  <= 1'b0;
              end
            endcase
          end else if (fin) begin
            armed <= 1'b0;
            case (ph)
              PH_START: begin
                ph      <= PH_INS;
                bit_cnt <= '0;
              end
              PH_INS: begin
                if (bit_cnt[0]) begin
                  bit_cnt <= '0;
                  if (is_dr)                  ph <= PH_LEN;
                  else if (op_q == OP_AR_WR)  ph <= PH_WBYTE;
                  else                        ph <= PH_RBYTE;
                end else begin
                  bit_cnt <= bit_cnt + 3'd1;
                end
              end
              PH_LEN: begin
                if (bit_cnt[0]) begin
                  bit_cnt <= '0;
                  ph      <= (op_q == OP_DR_WR) ? PH_WBYTE : PH_WAIT;
                end else begin
                  bit_cnt <= bit_cnt + 3'd1;
                end
              end
              PH_WBYTE: begin
                if (bit_cnt == 3'd7) begin
                  bit_cnt <= '0;
                  ph      <= (op_q == OP_AR_WR) ? PH_STOP : PH_WAIT;
                end else begin
                  bit_cnt <= bit_cnt + 3'd1;
                end
              end
              PH_RBYTE: begin
                sh <= {td_s, sh[7:1]};
                if (bit_cnt == 3'd7) begin
                  bit_cnt <= '0;
                  ph      <= PH_STOP;
                end else begin
                  bit_cnt <= bit_cnt + 3'd1;
                end
              end
              PH_WAIT: begin
                if (td_s) begin
                  wait_cnt <= '0;
                  ph       <= (op_q == OP_DR_RD) ? PH_RBYTE : PH_STOP;
                end else if (wait_cnt == WAIT_LAST) begin
                  tmo_err <= 1'b1;
                  ph      <= PH_END;
                end else begin
                  wait_cnt <= wait_cnt + WW'(1);
                end
              end
              default: ph <= PH_END;
            endcase
          end
        end
      endcase
    end
  end

endmodule

// File: rtl/tw_dbg_master.sv
module tw_dbg_master
  import tw_dbg_pkg::*;
#(
  parameter int CLK_MHZ     = 50,
  parameter int LOW_US      = 1,
  parameter int HIGH_US     = 1,
  parameter int RESET_US    = 25,
  parameter int WAIT_TRIES  = 20,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       link_en,
  input  logic       start,
  input  logic [2:0] cmd,
  input  logic [7:0] wr_byte,
  output logic [7:0] rd_byte,
  output logic       done,
  output logic       busy,
  output logic       tmo_err,
  output logic       ck_o,
  output logic       ck_oe,
  output logic       td_o,
  output logic       td_oe,
  input  logic       td_i
);

  localparam int LOW_CYC  = CLK_MHZ * LOW_US;
  localparam int HIGH_CYC = CLK_MHZ * HIGH_US;
  localparam int RST_CYC  = CLK_MHZ * RESET_US;

  logic                   go;
  logic                   long_low;
  logic                   fin;
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   td_s;
  tw_op_e                 act_op;

  // data input synchronizer, bit 0 is the first stage
  always_ff @(posedge clk) begin
    if (rst) sync_q <= '0;
    else     sync_q <= SYNC_STAGES'({sync_q, td_i});
  end
  assign td_s = sync_q[SYNC_STAGES-1];

  // clock drive follows the link enable; the level is already high at idle
  always_ff @(posedge clk) begin
    if (rst) ck_oe <= 1'b0;
    else     ck_oe <= link_en;
  end

  tw_strobe_gen #(
    .LOW_CYC (LOW_CYC),
    .HIGH_CYC(HIGH_CYC),
    .RST_CYC (RST_CYC)
  ) u_strobe (
    .clk     (clk),
    .rst     (rst),
    .go      (go),
    .long_low(long_low),
    .ck_o    (ck_o),
    .fin     (fin)
  );

  tw_frame_seq #(
    .WAIT_TRIES(WAIT_TRIES)
  ) u_seq (
    .clk     (clk),
    .rst     (rst),
    .start   (start),
    .link_en (link_en),
    .cmd     (cmd),
    .wr_byte (wr_byte),
    .td_s    (td_s),
    .fin     (fin),
    .go      (go),
    .long_low(long_low),
    .td_o    (td_o),
    .td_oe   (td_oe),
    .busy    (busy),
    .done    (done),
    .tmo_err (tmo_err),
    .rd_byte (rd_byte),
    .op_q    (act_op)
  );

endmodule

// File: rtl/tw_dbg_master_chk.sv
module tw_dbg_master_chk #(
  parameter int CLK_MHZ  = 50,
  parameter int RESET_US = 25
) (
  input logic       clk,
  input logic       rst,
  input logic       ck_o,
  input logic       ck_oe,
  input logic       td_oe,
  input logic       busy,
  input logic       done,
  input logic       tmo_err,
  input logic [2:0] act_op
);

  localparam int RST_CYC   = CLK_MHZ * RESET_US;
  localparam int LIMIT_CYC = 5 * CLK_MHZ;
  localparam int CW        = $clog2(RST_CYC + 2) + 1;

  logic [CW-1:0] lo_cnt;

  always_ff @(posedge clk) begin
    if (rst)                         lo_cnt <= '0;
    else if (!ck_o && !(&lo_cnt))    lo_cnt <= lo_cnt + CW'(1);
    else if (ck_o)                   lo_cnt <= '0;
  end

  // R2
  short_low_chk: assert property (@(posedge clk) disable iff (rst)
    (lo_cnt >= CW'(LIMIT_CYC)) |-> (act_op == 3'd4));

  // R3
  reset_low_bound_chk: assert property (@(posedge clk) disable iff (rst)
    lo_cnt <= CW'(RST_CYC));

  // R1
  idle_lines_chk: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (ck_o && !td_oe));

  // R11
  done_single_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R11
  op_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy)) |-> $stable(act_op));

  // R10
  tmo_then_done_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(tmo_err) |=> done);

  // R12
  clock_high_enable_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(ck_oe) |-> ck_o);

endmodule

bind tw_dbg_master tw_dbg_master_chk #(
  .CLK_MHZ (CLK_MHZ),
  .RESET_US(RESET_US)
) u_chk (
  .clk    (clk),
  .rst    (rst),
  .ck_o   (ck_o),
  .ck_oe  (ck_oe),
  .td_oe  (td_oe),
  .busy   (busy),
  .done   (done),
  .tmo_err(tmo_err),
  .act_op (act_op)
);

// File: tb/sim_tw_dbg_master.sv
module sim_tw_dbg_master;

  localparam int PERIOD   = 10;
  localparam int CLK_MHZ  = 4;
  localparam int LOW_CYC  = CLK_MHZ;
  localparam int HIGH_CYC = CLK_MHZ;
  localparam int RST_CYC  = CLK_MHZ * 25;
  localparam int TRIES    = 20;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       link_en = 1'b0;
  logic       start = 1'b0;
  logic [2:0] cmd = 3'd0;
  logic [7:0] wr_byte = 8'd0;
  logic       td_i = 1'b0;
  logic [7:0] rd_byte;
  logic       done, busy, tmo_err, ck_o, ck_oe, td_o, td_oe;

  always #(PERIOD/2) clk = ~clk;

  tw_dbg_master #(.CLK_MHZ(CLK_MHZ), .WAIT_TRIES(TRIES)) u0 (
    .clk(clk), .rst(rst), .link_en(link_en), .start(start), .cmd(cmd),
    .wr_byte(wr_byte), .rd_byte(rd_byte), .done(done), .busy(busy),
    .tmo_err(tmo_err), .ck_o(ck_o), .ck_oe(ck_oe), .td_o(td_o),
    .td_oe(td_oe), .td_i(td_i)
  );

  int errors = 0;
  int checks = 0;
  int cyc = 0;
  bit finished = 0;

  // target model and strobe recorder
  int         tgt_op = 0;
  int         tgt_k = 0;
  logic [7:0] tgt_byte = 8'd0;
  bit         rec_on = 0;
  int         s = 0;
  bit         rec_oe [0:63];
  bit         rec_td [0:63];
  bit         exp_oe [0:63];
  bit         exp_td [0:63];
  int         exp_n = 0;
  bit         exp_err = 0;
  bit         exp_stop = 0;
  logic [7:0] exp_rd = 8'd0;
  int         exp_lo = LOW_CYC;
  int         lo_bad = 0;
  int         hi_bad = 0;
  int         ndone = 0;
  longint     t_fall = 0;
  longint     t_rise = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic bit tgt_bit(input int idx);
    if (tgt_op == 1 && idx >= 3 && idx <= 10) return tgt_byte[idx-3];
    if (tgt_op == 3 && tgt_k > 0) begin
      if (idx == 4 + tgt_k) return 1'b1;
      if (idx >= 5 + tgt_k && idx <= 12 + tgt_k) return tgt_byte[idx-5-tgt_k];
    end
    if (tgt_op == 2 && tgt_k > 0 && idx == 12 + tgt_k) return 1'b1;
    return 1'b0;
  endfunction

  always @(negedge ck_o) begin
    if (rec_on) begin
      if (s > 0 && (($time - t_rise) / PERIOD) < HIGH_CYC) hi_bad++;
      t_fall = $time;
      if (s < 64) begin
        rec_oe[s] = td_oe;
        rec_td[s] = td_o;
      end
      td_i = tgt_bit(s);
      s++;
    end
  end

  always @(posedge ck_o) begin
    if (rec_on && s > 0) begin
      if (int'(($time - t_fall) / PERIOD) != exp_lo) lo_bad++;
      t_rise = $time;
    end
  end

  always @(negedge clk) begin
    if (done) ndone++;
    cyc++;
    if (cyc >= 190000 && !finished) begin
      finished = 1;
      errors++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic push(inout int n, input bit oe, input bit v);
    exp_oe[n] = oe;
    exp_td[n] = v;
    n++;
  endtask

  task automatic build_exp(input int op, input logic [7:0] w, input int k);
    int n = 0;
    bit ok = (k >= 1 && k <= TRIES);
    int waits = ok ? k : TRIES;
    logic [1:0] code = (op == 0) ? 2'b11 : (op == 1) ? 2'b10 : (op == 2) ? 2'b01 : 2'b00;
    exp_err  = 0;
    exp_stop = 1;
    if (op == 4) begin
      push(n, 0, 0);
      exp_stop = 0;
    end else begin
      push(n, 0, 0);
      push(n, 1, code[0]);
      push(n, 1, code[1]);
      if (op >= 2) begin
        push(n, 1, 0);
        push(n, 1, 0);
      end
      if (op == 0 || op == 2)
        for (int i = 0; i < 8; i++) push(n, 1, w[i]);
      if (op == 1)
        for (int i = 0; i < 8; i++) push(n, 0, 0);
      if (op >= 2) begin
        for (int i = 0; i < waits; i++) push(n, 0, 0);
        if (!ok) begin
          exp_err  = 1;
          exp_stop = 0;
        end
      end
      if (op == 3 && ok)
        for (int i = 0; i < 8; i++) push(n, 0, 0);
      if (exp_stop) push(n, 0, 0);
    end
    exp_n = n;
  endtask

  task automatic do_frame(input int op, input logic [7:0] w, input int k,
                          input logic [7:0] tb, input bit intrude);
    int guard = 0;
    int b4 = 0, b5 = 0, b6 = 0, bx = 0;
    int lim;
    string tag;
    tgt_op = op; tgt_k = k; tgt_byte = tb;
    build_exp(op, w, k);
    s = 0; lo_bad = 0; hi_bad = 0; ndone = 0;
    exp_lo = (op == 4) ? RST_CYC : LOW_CYC;
    rec_on = 1;
    @(negedge clk);
    cmd = 3'(op); wr_byte = w; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (ndone == 0 && guard < 20000) begin
      @(negedge clk);
      guard++;
      if (intrude && guard == 30) begin
        cmd = 3'(op ^ 1); wr_byte = ~w; start = 1'b1;
      end
      if (intrude && guard == 31) start = 1'b0;
    end
    repeat (40) @(negedge clk);
    rec_on = 0;
    tag = (op == 0 || op == 2) ? "R7" : (op == 1) ? "R8" : (op == 3) ? "R9" : "R3";
    chk(s == exp_n, exp_err ? "R10 strobe count" : {tag, " strobe count"}, s, exp_n);
    lim = (s < exp_n) ? s : exp_n;
    for (int p = 0; p < lim; p++) begin
      bit bad = (rec_oe[p] != exp_oe[p]) || (exp_oe[p] && rec_td[p] != exp_td[p]);
      if (bad) begin
        if (p == 0 || (exp_stop && p == exp_n - 1)) b4++;
        else if (p <= 2) b5++;
        else if (p <= 4 && op >= 2) b6++;
        else bx++;
      end
    end
    chk(b4 == 0, "R4 start/stop strobes", b4, 0);
    if (op != 4) begin
      chk(b5 == 0, "R5 instruction bits", b5, 0);
      chk(b6 == 0, "R6 length bits", b6, 0);
      chk(bx == 0, {tag, " payload strobes"}, bx, 0);
    end
    chk(ndone == 1, "R11 done pulses", ndone, 1);
    chk(lo_bad == 0, (op == 4) ? "R3 low width" : "R2 low width", lo_bad, 0);
    chk(hi_bad == 0, "R2 high width", hi_bad, 0);
    chk(tmo_err == exp_err, "R10 timeout flag", tmo_err, exp_err);
    if ((op == 1 || op == 3) && !exp_err) exp_rd = tb;
    chk(rd_byte == exp_rd, "R8 read byte", rd_byte, exp_rd);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk(ck_o == 1'b1 && td_oe == 1'b0 && ck_oe == 1'b0, "R1 lines after reset",
        {ck_o, td_oe, ck_oe}, 3'b100);
    chk(done == 0 && busy == 0 && tmo_err == 0 && rd_byte == 0, "R1 flags after reset",
        {done, busy, tmo_err, rd_byte}, 0);

    // R11 start with link disabled does nothing
    ndone = 0; s = 0; rec_on = 1;
    cmd = 3'd0; wr_byte = 8'h5A; start = 1'b1;
    @(negedge clk); start = 1'b0;
    repeat (100) @(negedge clk);
    chk(s == 0 && ndone == 0 && busy == 0, "R11 start while link off", s + ndone, 0);
    chk(ck_oe == 1'b0, "R12 clock enable while link off", ck_oe, 0);

    // R12 enable the link
    link_en = 1'b1;
    repeat (2) @(negedge clk);
    chk(ck_oe == 1'b1 && ck_o == 1'b1, "R12 clock driven high", {ck_oe, ck_o}, 3);

    // R11 undefined commands
    for (int c = 5; c < 8; c++) begin
      cmd = 3'(c); start = 1'b1;
      @(negedge clk); start = 1'b0;
      repeat (60) @(negedge clk);
      chk(s == 0 && ndone == 0 && busy == 0, "R11 undefined command ignored", s + ndone, 0);
    end
    rec_on = 0;

    // R3 target reset pulse
    do_frame(4, 8'h00, 0, 8'h00, 0);

    // main sweep over bytes, including all zeros and all ones
    for (int i = 0; i < 16; i++) begin
      logic [7:0] b = (i == 0) ? 8'h00 : (i == 1) ? 8'hFF : 8'(i * 37 + 3);
      do_frame(0, b, 0, 8'h00, 0);
      do_frame(1, 8'h00, 0, ~b, 0);
      do_frame(2, b, 1 + (i % 5), 8'h00, 0);
      do_frame(3, 8'h00, 1 + (i % 7), b ^ 8'h3C, 0);
    end

    // R9 wait boundary: ready on the last permitted strobe
    do_frame(2, 8'hA5, TRIES, 8'h00, 0);
    do_frame(3, 8'h00, TRIES, 8'h96, 0);

    // R10 timeout one past the limit, and never ready
    do_frame(2, 8'h0F, TRIES + 1, 8'h00, 0);
    repeat (50) @(negedge clk);
    chk(tmo_err == 1'b1, "R10 flag holds until next start", tmo_err, 1);
    do_frame(3, 8'h00, TRIES + 1, 8'h77, 0);
    do_frame(3, 8'h00, 0, 8'h11, 0);
    do_frame(0, 8'h81, 0, 8'h00, 0);

    // R11 start during a frame is ignored
    do_frame(1, 8'h00, 0, 8'hC3, 1);
    do_frame(2, 8'h6E, 3, 8'h00, 1);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule